// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block sits between instruction dispatch and the architectural register file of an out-of-order core. Dispatch allocates one slot per instruction at the tail, in program order, and is told which slot index the instruction received. Execution units finish in any order. Each one reports its result, or a fault, against that slot index. The buffer holds every result until the instruction becomes the oldest one in flight. Only then does it write the result to the register file. As a result, register state always moves forward in program order.

When the oldest instruction has finished with a fault, the block writes nothing for it. It pulses a flush carrying that instruction's PC, and it drops the faulting entry along with every younger entry, including any younger entries that have already completed. The register file then holds exactly the effects of the instructions older than the fault. The buffer restarts empty, with its slot index back at zero.

Top module: `reorder_buf`

## Requirements
- R1: While rst_ni is low, ret_we_o, flush_o and full_o are 0 and disp_idx_o is 0.
- R2: disp_idx_o shows the slot that the next accepted dispatch takes. Slots are handed out as 0, 1, ... DEPTH-1 and then wrap to 0.
- R3: full_o is 1 exactly when DEPTH entries are in flight. A dispatch offered while full_o is 1 is dropped, so disp_idx_o does not move and no retirement or flush is ever produced for it.
- R4: Completions may arrive in any slot order. Retirements (ret_we_o with ret_rd_o and ret_data_o) come out in dispatch order, at most one per cycle. A retirement is registered: it appears in the cycle after the head entry holds a non-faulting completion.
- R5: An incomplete head entry blocks all retirement, even if younger entries have already completed.
- R6: When the head entry completed with cmpl_exc_i set, flush_o is 1 for one cycle and flush_pc_o carries that entry's dispatch PC. ret_we_o stays 0 for that entry and for all younger entries. In the flush cycle the buffer is already empty: disp_idx_o is 0 and full_o is 0.
- R7: A completion that targets a slot holding no in-flight entry is ignored. A later dispatch into that slot still waits for its own completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request for one instruction |
| disp_rd_i | input | REG_W | Destination register of the dispatched instruction |
| disp_pc_i | input | PC_W | PC of the dispatched instruction |
| disp_idx_o | output | log2(DEPTH) | Slot the next dispatch receives |
| full_o | output | 1 | All slots are in flight |
| cmpl_valid_i | input | 1 | A completion is reported |
| cmpl_idx_i | input | log2(DEPTH) | Slot of the completing instruction |
| cmpl_data_i | input | DATA_W | Result value |
| cmpl_exc_i | input | 1 | The instruction faulted |
| ret_we_o | output | 1 | Register file write enable |
| ret_rd_o | output | REG_W | Register file write index |
| ret_data_o | output | DATA_W | Register file write data |
| flush_o | output | 1 | One-cycle pulse on a faulting head |
| flush_pc_o | output | PC_W | PC of the faulting instruction |

## Verification
The bench builds the block with DEPTH=4, 16-bit data and PCs, and 5-bit register indices. With only four slots, a few dispatches are enough to reach the full condition and to wrap the slot index across the end of the ring. This lets the bench check the dropped dispatch while full, and lets flushes and stray completions land at non-zero head positions. The small data width keeps the expected values readable and does not change the control paths.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    HEAD_WAIT   = 2'd0,
    HEAD_COMMIT = 2'd1,
    HEAD_FAULT  = 2'd2
  } head_act_e;
endpackage

// File: rtl/rob_ring_ctrl.sv
module rob_ring_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (alloc_i)  tail_q <= step(tail_q);
      if (retire_i) head_q <= step(head_q);
      cnt_q <= cnt_q + CNT_W'(alloc_i) - CNT_W'(retire_i);
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_slot_array.sv
module rob_slot_array #(
  parameter int DEPTH  = 16,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [REG_W-1:0]  alloc_rd_i,
  input  logic [PC_W-1:0]   alloc_pc_i,
  input  logic              cmpl_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  input  logic              cmpl_exc_i,
  input  logic              retire_i,
  input  logic [IDX_W-1:0]  head_idx_i,
  output logic              head_vld_o,
  output logic              head_done_o,
  output logic              head_exc_o,
  output logic [REG_W-1:0]  head_rd_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic [PC_W-1:0]   head_pc_o
);
  logic [DEPTH-1:0]  vld_q, done_q, exc_q;
  logic [REG_W-1:0]  rd_q   [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_alloc, hit_cmpl, hit_ret;
    assign hit_alloc = alloc_i  && (alloc_idx_i == IDX_W'(g));
    assign hit_cmpl  = cmpl_i   && (cmpl_idx_i  == IDX_W'(g)) && vld_q[g];
    assign hit_ret   = retire_i && (head_idx_i  == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        done_q[g] <= 1'b0;
        exc_q[g]  <= 1'b0;
        rd_q[g]   <= '0;
        data_q[g] <= '0;
        pc_q[g]   <= '0;
      end else if (flush_i) begin
        vld_q[g] <= 1'b0;
      end else begin
        if (hit_alloc) begin
          vld_q[g]  <= 1'b1;
          done_q[g] <= 1'b0;
          exc_q[g]  <= 1'b0;
          rd_q[g]   <= alloc_rd_i;
          pc_q[g]   <= alloc_pc_i;
        end else if (hit_ret) begin
          vld_q[g] <= 1'b0;
        end
        // stray completions to empty slots are dropped
        if (hit_cmpl) begin
          done_q[g] <= 1'b1;
          exc_q[g]  <= cmpl_exc_i;
          data_q[g] <= cmpl_data_i;
        end
      end
    end
  end

  assign head_vld_o  = vld_q[head_idx_i];
  assign head_done_o = done_q[head_idx_i];
  assign head_exc_o  = exc_q[head_idx_i];
  assign head_rd_o   = rd_q[head_idx_i];
  assign head_data_o = data_q[head_idx_i];
  assign head_pc_o   = pc_q[head_idx_i];
endmodule

// File: rtl/rob_head_arb.sv
module rob_head_arb
  import rob_pkg::*;
(
  input  logic      vld_i,
  input  logic      done_i,
  input  logic      exc_i,
  output head_act_e act_o
);
  always_comb begin
    act_o = HEAD_WAIT;
    if (vld_i && done_i) act_o = exc_i ? HEAD_FAULT : HEAD_COMMIT;
  end
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [REG_W-1:0]  disp_rd_i,
  input  logic [PC_W-1:0]   disp_pc_i,
  output logic [IDX_W-1:0]  disp_idx_o,
  output logic              full_o,
  input  logic              cmpl_valid_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  input  logic              cmpl_exc_i,
  output logic              ret_we_o,
  output logic [REG_W-1:0]  ret_rd_o,
  output logic [DATA_W-1:0] ret_data_o,
  output logic              flush_o,
  output logic [PC_W-1:0]   flush_pc_o
);
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              full, alloc, retire, fault;
  logic              h_vld, h_done, h_exc;
  logic [REG_W-1:0]  h_rd;
  logic [DATA_W-1:0] h_data;
  logic [PC_W-1:0]   h_pc;
  head_act_e         act;

  assign retire = (act == HEAD_COMMIT);
  assign fault  = (act == HEAD_FAULT);
  // a dispatch racing a fault is younger and is discarded
  assign alloc  = disp_valid_i && !full && !fault;

  rob_ring_ctrl #(.DEPTH(DEPTH)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alloc_i  (alloc),
    .retire_i (retire),
    .flush_i  (fault),
    .head_o   (head_idx),
    .tail_o   (tail_idx),
    .full_o   (full)
  );

  rob_slot_array #(
    .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)
  ) u_slots (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (fault),
    .alloc_i     (alloc),
    .alloc_idx_i (tail_idx),
    .alloc_rd_i  (disp_rd_i),
    .alloc_pc_i  (disp_pc_i),
    .cmpl_i      (cmpl_valid_i),
    .cmpl_idx_i  (cmpl_idx_i),
    .cmpl_data_i (cmpl_data_i),
    .cmpl_exc_i  (cmpl_exc_i),
    .retire_i    (retire),
    .head_idx_i  (head_idx),
    .head_vld_o  (h_vld),
    .head_done_o (h_done),
    .head_exc_o  (h_exc),
    .head_rd_o   (h_rd),
    .head_data_o (h_data),
    .head_pc_o   (h_pc)
  );

  rob_head_arb u_arb (
    .vld_i  (h_vld),
    .done_i (h_done),
    .exc_i  (h_exc),
    .act_o  (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_we_o   <= 1'b0;
      ret_rd_o   <= '0;
      ret_data_o <= '0;
      flush_o    <= 1'b0;
      flush_pc_o <= '0;
    end else begin
      ret_we_o <= retire;
      flush_o  <= fault;
      if (retire) begin
        ret_rd_o   <= h_rd;
        ret_data_o <= h_data;
      end
      if (fault) flush_pc_o <= h_pc;
    end
  end

  assign disp_idx_o = tail_idx;
  assign full_o     = full;
endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk #(
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             disp_valid_i,
  input logic [IDX_W-1:0] disp_idx_o,
  input logic             full_o,
  input logic             ret_we_o,
  input logic             flush_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!ret_we_o && !flush_o && !full_o && disp_idx_o == '0); // R1
    end
  end

  AST_DISP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && !full_o) |=> (flush_o ||
      disp_idx_o == (($past(disp_idx_o) == LAST) ? '0 : $past(disp_idx_o) + 1'b1))); // R2

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !ret_we_o) |=> (flush_o || disp_idx_o == $past(disp_idx_o))); // R3

  AST_NO_WRITE_ON_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ret_we_o && flush_o)); // R6

  AST_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o); // R6

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (disp_idx_o == '0 && !full_o)); // R6

  AST_NO_WRITE_AFTER_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !ret_we_o); // R6
endmodule

bind reorder_buf reorder_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_valid_i (disp_valid_i),
  .disp_idx_o   (disp_idx_o),
  .full_o       (full_o),
  .ret_we_o     (ret_we_o),
  .flush_o      (flush_o)
);

// File: tb/reorder_buf_tb.sv
`timescale 1ns/1ps
module reorder_buf_tb;
  localparam int DEPTH = 4, REG_W = 5, DATA_W = 16, PC_W = 16;
  localparam int IDX_W = $clog2(DEPTH);

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic              disp_valid_i = 1'b0;
  logic [REG_W-1:0]  disp_rd_i = '0;
  logic [PC_W-1:0]   disp_pc_i = '0;
  logic [IDX_W-1:0]  disp_idx_o;
  logic              full_o;
  logic              cmpl_valid_i = 1'b0;
  logic [IDX_W-1:0]  cmpl_idx_i = '0;
  logic [DATA_W-1:0] cmpl_data_i = '0;
  logic              cmpl_exc_i = 1'b0;
  logic              ret_we_o;
  logic [REG_W-1:0]  ret_rd_o;
  logic [DATA_W-1:0] ret_data_o;
  logic              flush_o;
  logic [PC_W-1:0]   flush_pc_o;

  always #4 clk_i = ~clk_i;

  reorder_buf #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_dut (.*);

  typedef struct {
    bit                is_flush;
    logic [REG_W-1:0]  rd;
    logic [DATA_W-1:0] val;
    string             req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_err = 0, n_ret = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push_ret(input logic [REG_W-1:0] rd, input logic [DATA_W-1:0] v, input string req);
    exp_t e;
    e.is_flush = 1'b0; e.rd = rd; e.val = v; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic push_flush(input logic [PC_W-1:0] pc, input string req);
    exp_t e;
    e.is_flush = 1'b1; e.rd = '0; e.val = pc; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk_i) begin
    if (rst_ni && (ret_we_o || flush_o)) begin
      if (ret_we_o) n_ret++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected output", {ret_we_o, flush_o}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_flush)
          check(flush_o && !ret_we_o && flush_pc_o == e.val, e.req, {flush_o, flush_pc_o}, {1'b1, e.val});
        else
          check(ret_we_o && !flush_o && ret_rd_o == e.rd && ret_data_o == e.val, e.req,
                {ret_we_o, ret_rd_o, ret_data_o}, {1'b1, e.rd, e.val});
      end
    end
  end

  task automatic disp(input logic [REG_W-1:0] rd, input logic [PC_W-1:0] pc);
    disp_valid_i = 1'b1; disp_rd_i = rd; disp_pc_i = pc;
    @(negedge clk_i);
    disp_valid_i = 1'b0;
  endtask

  task automatic cmpl(input int idx, input logic [DATA_W-1:0] d, input bit exc);
    cmpl_valid_i = 1'b1; cmpl_idx_i = IDX_W'(idx); cmpl_data_i = d; cmpl_exc_i = exc;
    @(negedge clk_i);
    cmpl_valid_i = 1'b0; cmpl_exc_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    int base;
    #20;
    check(!ret_we_o && !flush_o && !full_o && disp_idx_o == 0, "R1 reset",
          {ret_we_o, flush_o, full_o, disp_idx_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // out-of-order completion, in-order retire
    check(disp_idx_o == 0, "R2 first slot", disp_idx_o, 0);
    disp(5'd1, 16'h0100);
    check(disp_idx_o == 1, "R2 slot advance", disp_idx_o, 1);
    disp(5'd2, 16'h0104);
    disp(5'd3, 16'h0108);
    cmpl(2, 16'hC3C3, 1'b0);
    idle(3);
    check(n_ret == 0, "R5 head blocks younger", n_ret, 0);
    push_ret(5'd1, 16'hA1A1, "R4 order A");
    push_ret(5'd2, 16'hB2B2, "R4 order B");
    push_ret(5'd3, 16'hC3C3, "R4 order C");
    cmpl(0, 16'hA1A1, 1'b0);
    cmpl(1, 16'hB2B2, 1'b0);
    idle(4);
    drained("R4 all retired");
    check(n_ret == 3, "R4 retire count", n_ret, 3);

    // fill to full with wrap (tail at 3)
    disp(5'd10, 16'h0200);
    disp(5'd11, 16'h0204);
    disp(5'd12, 16'h0208);
    disp(5'd13, 16'h020C);
    check(full_o == 1'b1, "R3 full", full_o, 1);
    check(disp_idx_o == 3, "R2 wrap", disp_idx_o, 3);
    disp(5'd31, 16'hDEAD);
    check(disp_idx_o == 3 && full_o, "R3 dispatch ignored when full", disp_idx_o, 3);
    push_ret(5'd10, 16'h1010, "R3 ring 0");
    push_ret(5'd11, 16'h1111, "R3 ring 1");
    push_ret(5'd12, 16'h1212, "R3 ring 2");
    push_ret(5'd13, 16'h1313, "R3 ring 3");
    cmpl(1, 16'h1212, 1'b0);
    cmpl(3, 16'h1010, 1'b0);
    cmpl(2, 16'h1313, 1'b0);
    cmpl(0, 16'h1111, 1'b0);
    idle(4);
    drained("R3 dropped dispatch left no entry");
    check(n_ret == 7, "R3 retire count", n_ret, 7);
    check(!full_o, "R3 full cleared", full_o, 0);

    // faulting head with younger completed result
    base = n_ret;
    disp(5'd4, 16'h0300);
    disp(5'd2, 16'h0304);
    cmpl(0, 16'hEEEE, 1'b0);
    idle(2);
    check(n_ret == base, "R5 younger done waits", n_ret, base);
    push_flush(16'h0300, "R6 flush pc");
    cmpl(3, 16'h0000, 1'b1);
    idle(4);
    drained("R6 flush seen");
    check(n_ret == base, "R6 younger result discarded", n_ret, base);
    check(disp_idx_o == 0 && !full_o, "R6 empty after flush", disp_idx_o, 0);

    // stray completion to an empty slot
    cmpl(2, 16'h7777, 1'b0);
    base = n_ret;
    disp(5'd6, 16'h0400);
    disp(5'd7, 16'h0404);
    disp(5'd8, 16'h0408);
    push_ret(5'd6, 16'h6666, "R7 slot0");
    push_ret(5'd7, 16'h6767, "R7 slot1");
    cmpl(0, 16'h6666, 1'b0);
    cmpl(1, 16'h6767, 1'b0);
    idle(4);
    check(n_ret == base + 2, "R7 stray completion ignored", n_ret, base + 2);
    drained("R7 partial drain");
    push_ret(5'd8, 16'h6868, "R7 slot2");
    cmpl(2, 16'h6868, 1'b0);
    idle(4);
    drained("R7 own completion");

    // fault behind an older good entry (head at 3)
    base = n_ret;
    disp(5'd20, 16'h0500);
    disp(5'd21, 16'h0504);
    disp(5'd22, 16'h0508);
    cmpl(1, 16'h2222, 1'b0);
    cmpl(0, 16'h0000, 1'b1);
    push_ret(5'd20, 16'h2020, "R6 older retires first");
    push_flush(16'h0504, "R6 flush pc mid");
    cmpl(3, 16'h2020, 1'b0);
    idle(4);
    drained("R6 mid flush");
    check(n_ret == base + 1, "R6 only older written", n_ret, base + 1);
    check(disp_idx_o == 0, "R6 restart slot", disp_idx_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule